// File: doc/BRIEF.md
# TDM Quadrant Bit-Substitution Unit

This unit sits in the receive path of a serial time-division stream switch, after serial-to-parallel conversion. Each cycle that carries a channel, it receives the channel's byte, the channel's index within the frame, and the line-rate select. From these it works out which quarter of the frame the channel falls in. A "quarter" here is called a quadrant.

A per-stream control word holds one 3-bit code for each quadrant. That code either passes the byte through unchanged or forces its most or least significant bit to a fixed value. This lets a switch overwrite a signalling or framing bit across a whole region of the frame without touching the payload bits.

The control word is loaded through a simple write port and can be read back. The modified byte leaves the unit one clock after it arrives, together with a valid strobe.

Top module: `tdm_qsub`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `cfg_rdata` is 0 and `out_valid` is 0, so every quadrant starts in pass-through.
- R2: `out_valid` equals `in_valid` of the previous cycle, and `out_byte` is the result for the byte presented in that previous cycle (one-cycle latency).
- R3: Rate encoding is 0 for 32 channels, 1 for 64, 2 for 128 and 3 for 256 channels per frame. The quadrant is channel-index bits [4+rate:3+rate]. At 32 channels, quadrant 2 is channels 16..23 and quadrant 3 is 24..31. At 256 channels, quadrant 2 is 128..191 and quadrant 3 is 192..255. Index bits above the frame size are ignored.
- R4: The code for quadrant q sits in control bits [3q+2:3q], so quadrant 0 uses bits 2:0 and quadrant 3 uses bits 11:9.
- R5: A code whose top bit is 0 (0xx) passes the byte through unchanged.
- R6: Code 100 forces bit 7 of the byte to 0, and code 101 forces it to 1.
- R7: Code 110 forces bit 0 of the byte to 0, and code 111 forces it to 1.
- R8: Bits 6:1 of the byte are never modified.
- R9: Bits 15:12 of the control word ignore writes and always read back as 0. Bits 11:0 read back the last value written to them.
- R10: A write takes effect from the next channel onward. A channel presented in the same cycle as a write is processed with the previous control word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A channel byte is present this cycle |
| in_chan | input | 8 | Channel index within the frame |
| in_rate | input | 2 | Line-rate select (0..3 = 32..256 channels) |
| in_byte | input | 8 | Channel byte |
| cfg_we | input | 1 | Control word write enable |
| cfg_wdata | input | 16 | Control word write data |
| cfg_rdata | output | 16 | Control word readback |
| out_valid | output | 1 | Registered valid strobe |
| out_byte | output | 8 | Registered, possibly modified byte |

## Verification
Every channel index is swept at all four rates under a control word that gives each quadrant a different forcing code. A wrong quadrant boundary or a wrong field position therefore shows up as the wrong bit being forced on a specific channel. A second word with the codes permuted separates a swapped field from a swapped quadrant. A word holding only 0xx codes shows that pass-through leaves every bit alone.

Bytes of all zeros and all ones show whether a force actually changes the bit. Out-of-frame channel indices at the low rates confirm that high index bits are ignored. Writes that set the reserved bits, and writes issued in the same cycle as a channel, exercise readback and the timing of when an update applies.

// File: rtl/tdm_qsub_pkg.sv
package tdm_qsub_pkg;
  localparam int FIELD_W  = 3;
  localparam int NUM_QUAD = 4;
  localparam int QUAD_W   = 2;

  typedef enum logic [1:0] {
    ACT_KEEP_LO = 2'b00,
    ACT_KEEP_HI = 2'b01,
    ACT_MSB     = 2'b10,
    ACT_LSB     = 2'b11
  } act_e;

  typedef struct packed {
    logic enable;
    logic lsb_sel;
    logic value;
  } code_t;
endpackage

// File: rtl/qsub_cfg_reg.sv
module qsub_cfg_reg #(
  parameter int CTRL_W = 16,
  parameter int USED_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [CTRL_W-1:0] wdata,
  output logic [USED_W-1:0] word,
  output logic [CTRL_W-1:0] rdata
);
  localparam int PAD_W = CTRL_W - USED_W;

  always_ff @(posedge clk) begin
    if (rst) begin
      word <= '0;
    end else if (we) begin
      word <= wdata[USED_W-1:0];
    end
  end

  assign rdata = {{PAD_W{1'b0}}, word};
endmodule

// File: rtl/qsub_quad_sel.sv
module qsub_quad_sel #(
  parameter int CHAN_W    = 8,
  parameter int RATE_W    = 2,
  parameter int BASE_LOG2 = 5,
  parameter int QUAD_W    = 2
) (
  input  logic [CHAN_W-1:0] chan,
  input  logic [RATE_W-1:0] rate,
  output logic [QUAD_W-1:0] quad
);
  localparam int NUM_RATES = 1 << RATE_W;

  logic [QUAD_W-1:0] cand [NUM_RATES];

  genvar r;
  generate
    for (r = 0; r < NUM_RATES; r++) begin : g_rate
      assign cand[r] = chan[BASE_LOG2 + r - 1 -: QUAD_W];
    end
  endgenerate

  assign quad = cand[rate];
endmodule

// File: rtl/qsub_bit_force.sv
module qsub_bit_force
  import tdm_qsub_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  code_t             code,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);
  act_e act;

  always_comb begin
    act  = act_e'({code.enable, code.lsb_sel});
    dout = din;
    unique case (act)
      ACT_MSB: dout[DATA_W-1] = code.value;
      ACT_LSB: dout[0]        = code.value;
      default: dout           = din;
    endcase
  end
endmodule

// File: rtl/tdm_qsub.sv
module tdm_qsub
  import tdm_qsub_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int CHAN_W    = 8,
  parameter int RATE_W    = 2,
  parameter int BASE_LOG2 = 5,
  parameter int CTRL_W    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [CHAN_W-1:0] in_chan,
  input  logic [RATE_W-1:0] in_rate,
  input  logic [DATA_W-1:0] in_byte,
  input  logic              cfg_we,
  input  logic [CTRL_W-1:0] cfg_wdata,
  output logic [CTRL_W-1:0] cfg_rdata,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_byte
);
  localparam int USED_W = FIELD_W * NUM_QUAD;

  logic [USED_W-1:0] word;
  logic [QUAD_W-1:0] quad;
  code_t             fields [NUM_QUAD];
  code_t             sel_code;
  logic [DATA_W-1:0] forced;

  qsub_cfg_reg #(.CTRL_W(CTRL_W), .USED_W(USED_W)) u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .wdata(cfg_wdata),
    .word(word), .rdata(cfg_rdata)
  );

  qsub_quad_sel #(.CHAN_W(CHAN_W), .RATE_W(RATE_W),
                  .BASE_LOG2(BASE_LOG2), .QUAD_W(QUAD_W)) u_quad (
    .chan(in_chan), .rate(in_rate), .quad(quad)
  );

  genvar q;
  generate
    for (q = 0; q < NUM_QUAD; q++) begin : g_field
      assign fields[q] = code_t'(word[q*FIELD_W +: FIELD_W]);
    end
  endgenerate

  assign sel_code = fields[quad];

  qsub_bit_force #(.DATA_W(DATA_W)) u_force (
    .code(sel_code), .din(in_byte), .dout(forced)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_byte  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_byte <= forced;
    end
  end
endmodule

// File: rtl/tdm_qsub_chk.sv
module tdm_qsub_chk #(
  parameter int DATA_W = 8,
  parameter int CTRL_W = 16,
  parameter int USED_W = 12,
  parameter int FIELD_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [DATA_W-1:0] in_byte,
  input logic              cfg_we,
  input logic [CTRL_W-1:0] cfg_wdata,
  input logic [CTRL_W-1:0] cfg_rdata,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_byte
);
  logic all_pass;

  always_comb begin
    all_pass = 1'b1;
    for (int q = 0; q < USED_W / FIELD_W; q++) begin
      if (cfg_rdata[q*FIELD_W + FIELD_W - 1]) all_pass = 1'b0;
    end
  end

  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (cfg_rdata == '0 && !out_valid)); // R1

  AST_VALID_LAT: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> out_valid == $past(in_valid)); // R2

  AST_PASS_ALL: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(in_valid) && $past(all_pass) && !$past(cfg_we))
      |-> out_byte == $past(in_byte)); // R5

  AST_MID_KEEP: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_byte[DATA_W-2:1] == $past(in_byte[DATA_W-2:1])); // R8

  AST_WRITE_BACK: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(cfg_we)) |->
      (cfg_rdata[USED_W-1:0] == $past(cfg_wdata[USED_W-1:0]) &&
       cfg_rdata[CTRL_W-1:USED_W] == '0)); // R9
endmodule

bind tdm_qsub tdm_qsub_chk #(.DATA_W(DATA_W), .CTRL_W(CTRL_W)) chk_i (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte),
  .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
  .out_valid(out_valid), .out_byte(out_byte)
);

// File: tb/tdm_qsub_tb_top.sv
`timescale 1ns/1ps
module tdm_qsub_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [7:0]  in_chan = '0;
  logic [1:0]  in_rate = '0;
  logic [7:0]  in_byte = '0;
  logic        cfg_we = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic [15:0] cfg_rdata;
  logic        out_valid;
  logic [7:0]  out_byte;

  int total = 0;
  int bad = 0;
  bit done = 0;

  int          m_cfg = 0;
  bit          e_valid = 0;
  int          e_byte = 0;
  string       e_req = "R5";

  always #4 clk = ~clk;

  tdm_qsub dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_chan(in_chan),
    .in_rate(in_rate), .in_byte(in_byte), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .out_valid(out_valid), .out_byte(out_byte)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Reference model: R3 quadrant by arithmetic, R4 field slice, R5/R6/R7 codes,
  // R10 old word used for a channel presented with a write.
  always @(posedge clk) begin
    if (rst) begin
      e_valid = 0;
      m_cfg = 0;
    end else begin
      e_valid = in_valid;
      if (in_valid) begin
        int nch, idx, q, code, b;
        nch  = 32 << in_rate;
        idx  = in_chan % nch;
        q    = idx / (nch / 4);
        code = (m_cfg >> (3 * q)) & 7;
        b    = in_byte;
        e_req = "R5";
        if (code == 4) begin b = b & 8'h7F; e_req = "R6"; end
        if (code == 5) begin b = b | 8'h80; e_req = "R6"; end
        if (code == 6) begin b = b & 8'hFE; e_req = "R7"; end
        if (code == 7) begin b = b | 8'h01; e_req = "R7"; end
        e_byte = b;
      end
      if (cfg_we) m_cfg = cfg_wdata & 16'h0FFF;
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      check(out_valid == e_valid, "R2 valid", out_valid, e_valid);
      check(cfg_rdata == m_cfg[15:0], "R9 readback", cfg_rdata, m_cfg);
      if (e_valid)
        check(out_byte == e_byte[7:0], {e_req, " R3 R4 byte"}, out_byte, e_byte);
    end
  end

  task automatic write_cfg(input logic [15:0] w);
    @(negedge clk);
    in_valid  = 1'b0;
    cfg_we    = 1'b1;
    cfg_wdata = w;
    @(negedge clk);
    cfg_we    = 1'b0;
  endtask

  task automatic send(input int rate, input int ch, input int b);
    @(negedge clk);
    in_valid = 1'b1;
    in_rate  = rate[1:0];
    in_chan  = ch[7:0];
    in_byte  = b[7:0];
  endtask

  task automatic sweep(input int b_xor);
    for (int r = 0; r < 4; r++) begin
      for (int c = 0; c < (32 << r); c++) begin
        send(r, c, ((c * 37) ^ b_xor) & 8'hFF);
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(cfg_rdata == 16'h0 && out_valid == 1'b0, "R1 reset", cfg_rdata, 0);
    rst = 1'b0;
    @(negedge clk);
    check(cfg_rdata == 16'h0 && out_valid == 1'b0, "R1 after reset", cfg_rdata, 0);

    // R5: default pass-through across all rates
    sweep(8'h5A);
    // R3 R4 R6 R7: q0=100 q1=101 q2=110 q3=111
    write_cfg(16'b0000_111_110_101_100);
    sweep(8'h00);
    sweep(8'hFF);
    // permuted codes separate field from quadrant
    write_cfg(16'b0000_100_111_110_101);
    sweep(8'hA5);
    // R5: only 0xx codes
    write_cfg(16'b0000_011_010_001_000);
    sweep(8'h3C);
    // R3: out-of-frame index bits ignored at low rates
    write_cfg(16'b0000_111_100_110_101);
    for (int c = 32; c < 256; c += 5) send(0, c, 8'h81);
    for (int c = 64; c < 256; c += 7) send(1, c, 8'h7E);
    // R9: reserved bits ignored on write
    write_cfg(16'hF000);
    @(negedge clk);
    check(cfg_rdata == 16'h0000, "R9 reserved", cfg_rdata, 0);
    write_cfg(16'hFB6D);
    @(negedge clk);
    check(cfg_rdata == 16'h0B6D, "R9 reserved", cfg_rdata, 16'h0B6D);
    // R10: write in the same cycle as a channel
    write_cfg(16'h0000);
    @(negedge clk);
    in_valid = 1'b1; in_rate = 2'd0; in_chan = 8'd2; in_byte = 8'hFF;
    cfg_we = 1'b1; cfg_wdata = 16'h0004;
    @(negedge clk);
    check(out_byte == 8'hFF, "R10 old word", out_byte, 8'hFF);
    cfg_we = 1'b0; in_chan = 8'd3; in_byte = 8'hFF;
    @(negedge clk);
    check(out_byte == 8'h7F, "R10 new word", out_byte, 8'h7F);
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule